// File: doc/BRIEF.md
# Deflection fault guard with confirmed shutdown

The block watches two fault indications from the deflection stage: an over-voltage flag and a beam-current-limit flag. Each flag is captured in a sticky status bit. An interrupt line stays high for as long as any status bit is set. Reading the status leaves it unchanged. Software clears a bit by writing a one to its position.

A fault counts as real only after it survives a run of spaced checks. A divider built from the millisecond tick produces a check strobe every `CHECK_MS` ticks. A channel becomes confirmed when `CONFIRM_N` consecutive strobes find its status bit set. A strobe that finds the bit clear restarts that channel's run.

Software arms protection by setting a request bit. When a confirmed fault exists and the request bit is set, the block clears its own deflection-enable bit. The sequencer then runs a slow stop that lasts `RAMP_TICKS` millisecond ticks. At the end of the slow stop the horizontal output enable drops and protection mode is entered. Protection mode is held until reset.

If software clears the deflection enable itself, the sequencer runs the same slow stop and ends with the output off. Software can restart the output from that state.

The sequencer has four states:

| State | Meaning |
|---|---|
| ST_RUN | Output driven |
| ST_RAMP | Slow stop in progress |
| ST_OFF | Stopped by software |
| ST_PROT | Protection mode |

Its transitions are:

| Transition | Condition |
|---|---|
| RUN→RAMP | Enable low |
| RAMP→PROT | Ramp done with trip set |
| RAMP→OFF | Ramp done without trip |
| OFF→RUN | Enable written high |
| OFF→PROT | Trip set while off |
| PROT | Holds until reset |

Top module: `defl_guard_top`

## Requirements
- R1: A high `ovp_in` at a clock edge sets status bit 0 (address 0). `irq` is high whenever any status bit is set.
- R2: Reading leaves the status bits unchanged. Writing 1 to a status bit position at address 0 clears that bit. Writing 0 to it has no effect.
- R3: A high `bcl_in` sets status bit 1 (address 0) and raises `irq`.
- R4: Confirmed bits are bit 2 (over-voltage) and bit 3 (beam current) of address 0. A confirmed bit is set at the `CONFIRM_N`-th consecutive check strobe that finds the channel's status set. Strobes come every `CHECK_MS` ms ticks, counted from reset. A strobe that finds the status clear restarts the run. Once set, a confirmed bit holds until reset.
- R5: If a fault input is high in the same cycle as a clearing write to its bit, the bit stays set.
- R6: Address 1 holds bit 0 = deflection enable (reset 1) and bit 1 = protection request. When the request is set and any channel is confirmed, the enable clears on the next edge. With no confirmed channel, the request has no effect.
- R7: After the enable falls, `hout_en` stays high with `hout_stopping` high for `RAMP_TICKS` ms ticks, then `hout_en` drops. The end state is protection mode after an automatic clear, or off after a software clear.
- R8: Protection mode (`prot_mode`, also bit 2 of address 1) holds until reset. Writes of the enable bit are ignored while it holds.
- R9: Writing the enable bit to 1 while the sequencer is off, with no protection trip, restarts the output.
- R10: After reset: `hout_en`=1, `hout_stopping`=0, `prot_mode`=0, `irq`=0, all status bits 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| ovp_in | input | 1 | Over-voltage fault indication |
| bcl_in | input | 1 | Beam-current-limit fault indication |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read enable |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, zero when `rd_en` is low |
| irq | output | 1 | Interrupt, high while any status bit is set |
| hout_en | output | 1 | Horizontal output enable |
| hout_stopping | output | 1 | Slow stop in progress |
| prot_mode | output | 1 | Protection mode active |

## Verification
The hardest situation to reach is a confirmation run that breaks partway and then restarts. Reaching it needs a status clear that lands between two check strobes, and then a fresh run counted exactly to its last strobe. The bench builds the block with a short check period and drives every millisecond tick by hand from reset, so it always knows the divider phase. It clears the status after three strobes and then counts the fresh run strobe by strobe. The protection path is reached only through a real confirmation. Its slow-stop length is then checked one tick short of the end and at the end.

// File: rtl/defl_guard_pkg.sv
package defl_guard_pkg;
    localparam int NCH    = 2;
    localparam int CH_OVP = 0;
    localparam int CH_BCL = 1;

    localparam logic [1:0] ADDR_STAT = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;

    localparam int CTRL_EN  = 0;
    localparam int CTRL_REQ = 1;
    localparam int CTRL_PRT = 2;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_RAMP = 2'd1,
        ST_OFF  = 2'd2,
        ST_PROT = 2'd3
    } sd_state_e;
endpackage

// File: rtl/dg_check_timer.sv
module dg_check_timer #(
    parameter int CHECK_MS = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    output logic strobe
);
    localparam int CW = $clog2(CHECK_MS + 1);
    localparam logic [CW-1:0] LAST = CW'(CHECK_MS - 1);

    logic [CW-1:0] cnt;

    assign strobe = ms_tick && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (ms_tick) begin
            if (cnt == LAST) cnt <= '0;
            else             cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/dg_fault_chan.sv
module dg_fault_chan #(
    parameter int CONFIRM_N = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fault_in,
    input  logic clr,
    input  logic strobe,
    output logic stat,
    output logic conf
);
    localparam int RW = $clog2(CONFIRM_N + 1);
    localparam logic [RW-1:0] LAST = RW'(CONFIRM_N - 1);
    localparam logic [RW-1:0] FULL = RW'(CONFIRM_N);

    logic [RW-1:0] run;

    // sticky status: a live fault wins over a clearing write
    always_ff @(posedge clk) begin
        if (!rst_n) stat <= 1'b0;
        else        stat <= (stat && !clr) || fault_in;
    end

    // run of consecutive strobes that saw the status set
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run  <= '0;
            conf <= 1'b0;
        end else if (strobe) begin
            if (stat) begin
                if (run != FULL) run <= run + 1'b1;
                if (run == LAST) conf <= 1'b1;
            end else begin
                run <= '0;
            end
        end
    end
endmodule

// File: rtl/dg_shutdown_fsm.sv
module dg_shutdown_fsm
    import defl_guard_pkg::*;
#(
    parameter int RAMP_TICKS = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ms_tick,
    input  logic defl_en,
    input  logic trip,
    output logic hout_en,
    output logic hout_stopping,
    output logic prot_mode
);
    localparam int KW = $clog2(RAMP_TICKS + 1);
    localparam logic [KW-1:0] LAST = KW'(RAMP_TICKS - 1);

    sd_state_e     state, state_nx;
    logic [KW-1:0] ramp_cnt;
    logic          ramp_done;

    assign ramp_done = ms_tick && (ramp_cnt == LAST);

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_RUN;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                             ramp_cnt <= '0;
        else if (state != ST_RAMP)              ramp_cnt <= '0;
        else if (ms_tick && ramp_cnt != LAST)   ramp_cnt <= ramp_cnt + 1'b1;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_RUN:  if (!defl_en) state_nx = ST_RAMP;
            ST_RAMP: if (ramp_done) state_nx = trip ? ST_PROT : ST_OFF;
            ST_OFF: begin
                if (trip)         state_nx = ST_PROT;
                else if (defl_en) state_nx = ST_RUN;
            end
            ST_PROT: state_nx = ST_PROT;
            default: state_nx = ST_RUN;
        endcase
    end

    always_comb begin
        hout_en       = 1'b0;
        hout_stopping = 1'b0;
        prot_mode     = 1'b0;
        unique case (state)
            ST_RUN:  hout_en = 1'b1;
            ST_RAMP: begin
                hout_en       = 1'b1;
                hout_stopping = 1'b1;
            end
            ST_OFF:  hout_en = 1'b0;
            ST_PROT: prot_mode = 1'b1;
            default: hout_en = 1'b0;
        endcase
    end
endmodule

// File: rtl/defl_guard_top.sv
module defl_guard_top
    import defl_guard_pkg::*;
#(
    parameter int CHECK_MS   = 50,
    parameter int CONFIRM_N  = 5,
    parameter int RAMP_TICKS = 20
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ms_tick,
    input  logic       ovp_in,
    input  logic       bcl_in,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic       irq,
    output logic       hout_en,
    output logic       hout_stopping,
    output logic       prot_mode
);
    logic [NCH-1:0] fault_in;
    logic [NCH-1:0] clr;
    logic [NCH-1:0] stat;
    logic [NCH-1:0] conf;
    logic           strobe;
    logic           defl_en;
    logic           prot_req;
    logic           trip;
    logic           wr_stat;
    logic           wr_ctrl;

    assign fault_in[CH_OVP] = ovp_in;
    assign fault_in[CH_BCL] = bcl_in;
    assign wr_stat = wr_en && (addr == ADDR_STAT);
    assign wr_ctrl = wr_en && (addr == ADDR_CTRL);
    assign irq     = |stat;

    dg_check_timer #(.CHECK_MS(CHECK_MS)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .ms_tick(ms_tick),
        .strobe (strobe)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        assign clr[i] = wr_stat && wdata[i];
        dg_fault_chan #(.CONFIRM_N(CONFIRM_N)) u_chan (
            .clk     (clk),
            .rst_n   (rst_n),
            .fault_in(fault_in[i]),
            .clr     (clr[i]),
            .strobe  (strobe),
            .stat    (stat[i]),
            .conf    (conf[i])
        );
    end

    // control register; the automatic clear outranks a same-cycle write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            defl_en  <= 1'b1;
            prot_req <= 1'b0;
            trip     <= 1'b0;
        end else begin
            if (wr_ctrl) begin
                prot_req <= wdata[CTRL_REQ];
                if (!trip) defl_en <= wdata[CTRL_EN];
            end
            if (!trip && prot_req && (|conf)) begin
                trip    <= 1'b1;
                defl_en <= 1'b0;
            end
        end
    end

    dg_shutdown_fsm #(.RAMP_TICKS(RAMP_TICKS)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .ms_tick      (ms_tick),
        .defl_en      (defl_en),
        .trip         (trip),
        .hout_en      (hout_en),
        .hout_stopping(hout_stopping),
        .prot_mode    (prot_mode)
    );

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            unique case (addr)
                ADDR_STAT: begin
                    rdata[NCH-1:0]     = stat;
                    rdata[2*NCH-1:NCH] = conf;
                end
                ADDR_CTRL: begin
                    rdata[CTRL_EN]  = defl_en;
                    rdata[CTRL_REQ] = prot_req;
                    rdata[CTRL_PRT] = prot_mode;
                end
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/defl_guard_chk.sv
module defl_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ovp_in,
    input logic       bcl_in,
    input logic       wr_en,
    input logic [1:0] addr,
    input logic [7:0] wdata,
    input logic       irq,
    input logic       hout_en,
    input logic       hout_stopping,
    input logic       prot_mode,
    input logic [1:0] stat,
    input logic [1:0] conf,
    input logic       prot_req,
    input logic       defl_en
);
    AST_OVP_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        ovp_in |=> irq); // R1
    AST_BCL_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        bcl_in |=> irq); // R3
    AST_STAT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (stat[0] && !(wr_en && addr == 2'd0 && wdata[0])) |=> stat[0]); // R2
    AST_CONF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        conf[0] |=> conf[0]); // R4
    AST_AUTO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        ((|conf) && prot_req && defl_en) |=> !defl_en); // R6
    AST_STOP_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        hout_stopping |-> hout_en); // R7
    AST_PROT_OUT_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        prot_mode |-> !hout_en); // R7
    AST_PROT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        prot_mode |=> prot_mode); // R8
endmodule

bind defl_guard_top defl_guard_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ovp_in       (ovp_in),
    .bcl_in       (bcl_in),
    .wr_en        (wr_en),
    .addr         (addr),
    .wdata        (wdata),
    .irq          (irq),
    .hout_en      (hout_en),
    .hout_stopping(hout_stopping),
    .prot_mode    (prot_mode),
    .stat         (stat),
    .conf         (conf),
    .prot_req     (prot_req),
    .defl_en      (defl_en)
);

// File: tb/sim_defl_guard_top.sv
module sim_defl_guard_top;
    localparam int CLK_PERIOD = 10;
    localparam int CHK = 4;
    localparam int CNF = 5;
    localparam int RMP = 6;
    localparam int NVEC = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ms_tick = 1'b0;
    logic       ovp_in = 1'b0;
    logic       bcl_in = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'd0;
    logic [7:0] rdata;
    logic       irq, hout_en, hout_stopping, prot_mode;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    defl_guard_top #(.CHECK_MS(CHK), .CONFIRM_N(CNF), .RAMP_TICKS(RMP)) u0 (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .ovp_in(ovp_in),
        .bcl_in(bcl_in), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .irq(irq), .hout_en(hout_en),
        .hout_stopping(hout_stopping), .prot_mode(prot_mode)
    );

    // {ovp, bcl, wr, waddr[1:0], wdata[7:0], raddr[1:0], exp[7:0], exp_irq}
    localparam logic [23:0] VEC [NVEC] = '{
        {1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 2'd0, 8'h00, 1'b0}, // R10 idle
        {1'b1, 1'b0, 1'b0, 2'd0, 8'h00, 2'd0, 8'h01, 1'b1}, // R1 set
        {1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 2'd0, 8'h01, 1'b1}, // R2 read keeps
        {1'b0, 1'b0, 1'b1, 2'd0, 8'h01, 2'd0, 8'h00, 1'b0}, // R2 w1c
        {1'b0, 1'b1, 1'b0, 2'd0, 8'h00, 2'd0, 8'h02, 1'b1}, // R3 set
        {1'b0, 1'b0, 1'b1, 2'd0, 8'h01, 2'd0, 8'h02, 1'b1}, // R2 other bit
        {1'b0, 1'b0, 1'b1, 2'd0, 8'h02, 2'd0, 8'h00, 1'b0}, // R2 w1c bcl
        {1'b1, 1'b0, 1'b1, 2'd0, 8'h01, 2'd0, 8'h01, 1'b1}, // R5 set wins
        {1'b0, 1'b0, 1'b1, 2'd0, 8'h01, 2'd0, 8'h00, 1'b0}, // R2 w1c
        {1'b0, 1'b0, 1'b0, 2'd0, 8'h00, 2'd1, 8'h01, 1'b0}  // R10 ctrl
    };

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) ms_tick = 1'b1;
            @(negedge clk) ms_tick = 1'b0;
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; wdata = 8'h00;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        addr = a; rd_en = 1'b1;
        #1 d = rdata;
        rd_en = 1'b0;
    endtask

    task automatic pulse_ovp();
        @(negedge clk) ovp_in = 1'b1;
        @(negedge clk) ovp_in = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        do_reset();
        #1;
        check("R10 hout_en", {7'd0, hout_en}, 8'h01);
        check("R10 stopping", {7'd0, hout_stopping}, 8'h00);
        check("R10 prot_mode", {7'd0, prot_mode}, 8'h00);
        check("R10 irq", {7'd0, irq}, 8'h00);

        for (int k = 0; k < NVEC; k++) begin
            @(negedge clk);
            ovp_in = VEC[k][23]; bcl_in = VEC[k][22]; wr_en = VEC[k][21];
            addr = VEC[k][20:19]; wdata = VEC[k][18:11];
            @(negedge clk);
            ovp_in = 1'b0; bcl_in = 1'b0; wr_en = 1'b0; wdata = 8'h00;
            rd(VEC[k][10:9], r);
            check($sformatf("R1/R2/R3/R5 row %0d rdata", k), r, VEC[k][8:1]);
            check($sformatf("R1/R3 row %0d irq", k), {7'd0, irq}, {7'd0, VEC[k][0]});
        end

        // R4: plain run, strobes every CHK ticks from reset
        do_reset();
        pulse_ovp();
        tick(CHK * CNF - 1);
        rd(2'd0, r); check("R4 one strobe short", r, 8'h01);
        tick(1);
        rd(2'd0, r); check("R4 confirmed", r, 8'h05);

        // R4: broken run restarts
        do_reset();
        pulse_ovp();
        tick(CHK * 3);
        wr(2'd0, 8'h01);
        tick(CHK);
        pulse_ovp();
        tick(CHK * (CNF - 1));
        rd(2'd0, r); check("R4 restarted run short", r, 8'h01);
        tick(CHK);
        rd(2'd0, r); check("R4 restarted run confirmed", r, 8'h05);

        // R6: request without a confirmed fault does nothing
        do_reset();
        wr(2'd1, 8'h03);
        repeat (3) @(negedge clk);
        rd(2'd1, r); check("R6 no confirm no clear", r, 8'h03);
        tick(RMP);
        check("R6 output kept", {7'd0, hout_en}, 8'h01);

        // R6/R7/R8: confirmed beam fault, automatic clear, slow stop, protection
        do_reset();
        @(negedge clk) bcl_in = 1'b1;
        @(negedge clk) bcl_in = 1'b0;
        tick(CHK * CNF);
        rd(2'd0, r); check("R4 beam confirmed", r, 8'h0A);
        wr(2'd1, 8'h03);
        @(negedge clk);
        rd(2'd1, r); check("R6 enable auto cleared", r, 8'h02);
        @(negedge clk);
        check("R7 stopping", {6'd0, hout_en, hout_stopping}, 8'h03);
        tick(RMP - 1);
        check("R7 still ramping", {6'd0, hout_en, hout_stopping}, 8'h03);
        tick(1);
        check("R7 output dropped", {6'd0, hout_en, prot_mode}, 8'h01);
        wr(2'd1, 8'h01);
        tick(2);
        rd(2'd1, r); check("R8 enable write ignored", r, 8'h04);
        check("R8 protection held", {6'd0, hout_en, prot_mode}, 8'h01);

        // R7/R9: software stop ends off, then restart
        do_reset();
        wr(2'd1, 8'h00);
        @(negedge clk);
        check("R7 soft ramp", {6'd0, hout_en, hout_stopping}, 8'h03);
        tick(RMP);
        check("R7 soft off", {5'd0, hout_en, hout_stopping, prot_mode}, 8'h00);
        wr(2'd1, 8'h01);
        @(negedge clk);
        check("R9 restarted", {6'd0, hout_en, prot_mode}, 8'h02);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule